// File: doc/BRIEF.md
# Set-Associative Data Cache with RAM Tags

This block is a small primary data cache made of several ways. Each way is its own sub-bank, with a tag RAM and a data RAM. A load or store address splits into a tag, a set index, a word select and a byte offset. The index picks one set across all ways. The tag stored in each way of that set is compared with the request tag. Each line carries a valid bit, and all valid bits are cleared by reset.

A parameter selects one of two load timings. In the parallel timing, the tags and the addressed word of every way are read together, and the comparison results pick the word to return. In the two-phase timing, only the tags are read at first, and the addressed word is read afterwards from the single matching way. A two-phase load therefore takes one extra cycle. With a single way, the data read always starts together with the tag read, because there is no way to choose.

Stores check the tag in one cycle and write the word in the next. On a miss, the block reads the whole 8-word line from the next memory level, one word at a time, and writes it into a victim way. Each set has a round-robin pointer that chooses the victim. The access completes on the cycle in which the last word is written. Dirty data is never written back.

Top module: `sa_cache`

## Requirements
- R1: After reset, resp_ready and mem_req_valid are low and every line is invalid, so the first access to any address completes with resp_hit low.
- R2: Address fields, from least significant bit: bits [1:0] are the byte offset and are ignored; the next 3 bits select one of 8 words; the next $clog2(SETS) bits select the set; the remaining upper bits form the tag.
- R3: With TWO_PHASE=0, a load hit raises resp_ready with resp_hit high on the second rising edge, counting the edge that accepts the request as the first. resp_rdata then holds the word stored at the addressed location.
- R4: With TWO_PHASE=1 and more than one way, a load hit raises resp_ready with resp_hit high one edge later, on the third edge, and returns the correct word.
- R5: A store hit raises resp_ready with resp_hit high on the third edge, in both modes. A later load of the same address returns the stored data.
- R6: A miss issues exactly 8 memory requests. Their word addresses are {tag, index, 0} up to {tag, index, 7}, in ascending order. mem_req_valid is a one-cycle pulse, and the next request is issued only after the response to the previous one has arrived.
- R7: A load miss raises resp_ready with resp_hit low on the same edge that writes the final refill word. resp_rdata then holds the requested word as returned by memory.
- R8: A store miss allocates the line. The store data replaces the refilled word at its position, and a later load of that address hits and returns the store data.
- R9: The victim way is taken from a per-set round-robin pointer. The pointer starts at way 0 and advances on every fill. A fill evicts only the line in that way of that set; every other line stays resident.
- R10: At most one way matches in the lookup cycle, and the word returned on a hit comes from the way that matched.
- R11: resp_ready is a one-cycle pulse. A new request is accepted only when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until resp_ready is seen |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| resp_ready | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Completed access was a hit |
| resp_rdata | output | DATA_W | Load data, valid while resp_ready is high |
| mem_req_valid | output | 1 | Refill word request pulse |
| mem_req_addr | output | ADDR_W-2 | Refill word address |
| mem_resp_valid | input | 1 | Refill word returned |
| mem_resp_data | input | DATA_W | Refill word data |

## Verification
The bench fills every set in turn and then reads back every word of every way, using each byte offset. A design that decodes the address fields wrongly, or that takes a hit word from the wrong way, returns data that does not match the memory pattern. Hit latency is counted edge by edge in both timing modes. A two-phase design that forgets its extra data cycle, or a store that writes in the tag-check cycle, is caught by a latency mismatch. The bench then runs an eviction sequence on one set. A wrong round-robin order, a pointer that fails to advance, or a fill that clobbers another line shows up as an unexpected hit or miss. A store miss must land in the freshly refilled line, and a design that drops the merge returns the memory word instead of the stored one.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_DREAD,
    ST_WRITE,
    ST_REFILL
  } cache_state_t;
endpackage

// File: rtl/sa_cache_way.sv
// One way: a tag RAM and a word-wide data RAM, both with registered read ports.
module sa_cache_way #(
  parameter int TAG_W  = 9,
  parameter int SETS   = 4,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int DA_W  = $clog2(SETS) + $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              tag_re,
  input  logic [IDX_W-1:0]  tag_raddr,
  output logic [TAG_W-1:0]  tag_rdata,
  input  logic              tag_we,
  input  logic [IDX_W-1:0]  tag_waddr,
  input  logic [TAG_W-1:0]  tag_wdata,
  input  logic              data_re,
  input  logic [DA_W-1:0]   data_raddr,
  output logic [DATA_W-1:0] data_rdata,
  input  logic              data_we,
  input  logic [DA_W-1:0]   data_waddr,
  input  logic [DATA_W-1:0] data_wdata
);
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS*WORDS];

  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[tag_waddr] <= tag_wdata;
    if (tag_re) tag_rdata <= tag_mem[tag_raddr];
  end

  always_ff @(posedge clk) begin
    if (data_we) data_mem[data_waddr] <= data_wdata;
    if (data_re) data_rdata <= data_mem[data_raddr];
  end
endmodule

// File: rtl/sa_cache_match.sv
// Concurrent tag comparison across all ways, with a one-hot to index encoder.
module sa_cache_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 9,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] stored_tag,
  input  logic [WAYS-1:0]            line_valid,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic [WAYS-1:0]            match_vec,
  output logic                       match_any,
  output logic [WAY_W-1:0]           match_idx
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = line_valid[w] && (stored_tag[w] == probe_tag);
  end

  assign match_any = |match_vec;

  always_comb begin
    match_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_vec[w]) match_idx = match_idx | WAY_W'(w);
    end
  end
endmodule

// File: rtl/sa_cache_ctrl.sv
// Access sequencer: lookup, optional data phase, store write, line refill.
module sa_cache_ctrl
  import sa_cache_pkg::*;
#(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 9,
  parameter bit TP_EFF = 1'b0,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [OFF_W-1:0]  req_word,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              match_any,
  input  logic [WAY_W-1:0]  match_idx,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data,
  output logic              accept,
  output logic              lookup_active,
  output logic              dread,
  output logic [WAYS-1:0]   line_valid,
  output logic [TAG_W-1:0]  tag_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [OFF_W-1:0]  word_q,
  output logic              wr_q,
  output logic [WAY_W-1:0]  way_q,
  output logic              tag_we,
  output logic              data_we,
  output logic [OFF_W-1:0]  data_wword,
  output logic [DATA_W-1:0] data_wdata,
  output logic              mem_req_valid,
  output logic [OFF_W-1:0]  fill_word,
  output logic              resp_ready,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic [DATA_W-1:0] miss_word
);
  cache_state_t      state;
  logic [DATA_W-1:0] wdata_q;
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAY_W-1:0]  rr_q    [SETS];
  logic [OFF_W-1:0]  cnt_q;
  logic              pend_q;
  logic              fill_beat;
  logic              last_beat;
  logic [WAY_W-1:0]  rr_next;

  assign accept        = (state == ST_IDLE) && req_valid;
  assign lookup_active = (state == ST_LOOKUP);
  assign dread         = (state == ST_DREAD);
  assign line_valid    = valid_q[idx_q];
  assign fill_beat     = (state == ST_REFILL) && pend_q && mem_resp_valid;
  assign last_beat     = (cnt_q == OFF_W'(WORDS - 1));
  assign rr_next       = (rr_q[idx_q] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx_q] + 1'b1;

  assign mem_req_valid = (state == ST_REFILL) && !pend_q;
  assign fill_word     = cnt_q;
  assign tag_we        = fill_beat && last_beat;
  assign data_we       = (state == ST_WRITE) || fill_beat;
  assign data_wword    = (state == ST_WRITE) ? word_q : cnt_q;
  assign data_wdata    = ((state == ST_WRITE) || (wr_q && cnt_q == word_q)) ? wdata_q : mem_resp_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_ready <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      tag_q      <= '0;
      idx_q      <= '0;
      word_q     <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      way_q      <= '0;
      miss_word  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      resp_ready <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            tag_q   <= req_tag;
            idx_q   <= req_idx;
            word_q  <= req_word;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            state   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (match_any) begin
            way_q <= match_idx;
            if (wr_q) begin
              state <= ST_WRITE;
            end else if (TP_EFF) begin
              state <= ST_DREAD;
            end else begin
              state      <= ST_IDLE;
              resp_ready <= 1'b1;
              resp_hit   <= 1'b1;
              resp_miss  <= 1'b0;
            end
          end else begin
            way_q  <= rr_q[idx_q];
            cnt_q  <= '0;
            pend_q <= 1'b0;
            state  <= ST_REFILL;
          end
        end
        ST_DREAD, ST_WRITE: begin
          state      <= ST_IDLE;
          resp_ready <= 1'b1;
          resp_hit   <= 1'b1;
          resp_miss  <= 1'b0;
        end
        ST_REFILL: begin
          if (mem_req_valid) pend_q <= 1'b1;
          if (fill_beat) begin
            pend_q <= 1'b0;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == word_q) miss_word <= mem_resp_data;
            if (last_beat) begin
              valid_q[idx_q][way_q] <= 1'b1;
              rr_q[idx_q]           <= rr_next;
              state                 <= ST_IDLE;
              resp_ready            <= 1'b1;
              resp_hit              <= 1'b0;
              resp_miss             <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_cache.sv
// Set-associative data cache with per-way tag RAMs; TWO_PHASE selects load timing.
module sa_cache #(
  parameter int ADDR_W    = 16,
  parameter int WAYS      = 2,
  parameter int SETS      = 4,
  parameter int WORDS     = 8,
  parameter int DATA_W    = 32,
  parameter int TWO_PHASE = 0,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W,
  localparam int MEM_AW = ADDR_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_ready,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req_valid,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data
);
  localparam int  WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int  DA_W   = IDX_W + OFF_W;
  localparam bit  TP_EFF = (TWO_PHASE != 0) && (WAYS > 1);

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_word;
  logic              unused_byte_bits;

  assign req_word = req_addr[BYTE_W +: OFF_W];
  assign req_idx  = req_addr[BYTE_W + OFF_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_byte_bits = ^req_addr[BYTE_W-1:0];

  logic                      accept;
  logic                      lookup_active;
  logic                      dread;
  logic [WAYS-1:0]           line_valid;
  logic [TAG_W-1:0]          tag_q;
  logic [IDX_W-1:0]          idx_q;
  logic [OFF_W-1:0]          word_q;
  logic                      wr_q;
  logic [WAY_W-1:0]          way_q;
  logic                      tag_we;
  logic                      data_we;
  logic [OFF_W-1:0]          data_wword;
  logic [DATA_W-1:0]         data_wdata;
  logic [OFF_W-1:0]          fill_word;
  logic                      resp_miss;
  logic [DATA_W-1:0]         miss_word;
  logic [WAYS-1:0]           match_vec;
  logic                      match_any;
  logic [WAY_W-1:0]          match_idx;
  logic [WAYS-1:0][TAG_W-1:0]  tag_rd;
  logic [WAYS-1:0][DATA_W-1:0] data_rd;
  logic [WAYS-1:0]           data_re_vec;
  logic [DA_W-1:0]           data_raddr;
  logic [DA_W-1:0]           data_waddr;
  logic [DATA_W-1:0]         hit_word;

  sa_cache_ctrl #(
    .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W), .TP_EFF(TP_EFF)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_tag(req_tag), .req_idx(req_idx), .req_word(req_word), .req_wdata(req_wdata),
    .match_any(match_any), .match_idx(match_idx),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .accept(accept), .lookup_active(lookup_active), .dread(dread),
    .line_valid(line_valid),
    .tag_q(tag_q), .idx_q(idx_q), .word_q(word_q), .wr_q(wr_q), .way_q(way_q),
    .tag_we(tag_we), .data_we(data_we), .data_wword(data_wword), .data_wdata(data_wdata),
    .mem_req_valid(mem_req_valid), .fill_word(fill_word),
    .resp_ready(resp_ready), .resp_hit(resp_hit), .resp_miss(resp_miss), .miss_word(miss_word)
  );

  sa_cache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .stored_tag(tag_rd), .line_valid(line_valid), .probe_tag(tag_q),
    .match_vec(match_vec), .match_any(match_any), .match_idx(match_idx)
  );

  assign data_waddr   = {idx_q, data_wword};
  assign mem_req_addr = {tag_q, idx_q, fill_word};

  if (TP_EFF) begin : g_two_phase
    assign data_raddr = {idx_q, word_q};
  end else begin : g_parallel
    assign data_raddr = {req_idx, req_word};
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    if (TP_EFF) begin : g_re_one
      assign data_re_vec[w] = dread && (way_q == WAY_W'(w));
    end else begin : g_re_all
      assign data_re_vec[w] = accept;
    end

    sa_cache_way #(.TAG_W(TAG_W), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_way (
      .clk(clk),
      .tag_re(accept), .tag_raddr(req_idx), .tag_rdata(tag_rd[w]),
      .tag_we(tag_we && (way_q == WAY_W'(w))), .tag_waddr(idx_q), .tag_wdata(tag_q),
      .data_re(data_re_vec[w]), .data_raddr(data_raddr), .data_rdata(data_rd[w]),
      .data_we(data_we && (way_q == WAY_W'(w))), .data_waddr(data_waddr), .data_wdata(data_wdata)
    );
  end

  if (WAYS == 1) begin : g_direct
    assign hit_word = data_rd[0];
  end else begin : g_assoc
    assign hit_word = data_rd[way_q];
  end

  assign resp_rdata = resp_miss ? miss_word : hit_word;
endmodule

// File: rtl/sa_cache_checker.sv
module sa_cache_checker #(
  parameter int WAYS   = 2,
  parameter int WORDS  = 8,
  parameter bit TP_EFF = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            lookup_active,
  input logic [WAYS-1:0] match_vec,
  input logic            match_any,
  input logic            is_write,
  input logic            resp_ready,
  input logic            resp_hit,
  input logic            mem_req_valid
);
  int unsigned beats;

  always_ff @(posedge clk) begin
    if (rst || lookup_active) beats <= 0;
    else if (mem_req_valid)   beats <= beats + 1;
  end

  assert_match_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    lookup_active |-> $onehot0(match_vec));

  assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    resp_ready |=> !resp_ready);

  assert_fast_load_R3: assert property (@(posedge clk) disable iff (rst)
    (lookup_active && match_any && !is_write && !TP_EFF) |=> (resp_ready && resp_hit));

  assert_slow_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (lookup_active && match_any && (is_write || TP_EFF)) |=> !resp_ready ##1 (resp_ready && resp_hit));

  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  assert_refill_length_R6: assert property (@(posedge clk) disable iff (rst)
    (resp_ready && !resp_hit) |-> (beats == WORDS));

  assert_no_req_while_resp_R7: assert property (@(posedge clk) disable iff (rst)
    resp_ready |-> !mem_req_valid);
endmodule

bind sa_cache sa_cache_checker #(.WAYS(WAYS), .WORDS(WORDS), .TP_EFF(TP_EFF)) u_checker (
  .clk(clk), .rst(rst), .lookup_active(lookup_active), .match_vec(match_vec),
  .match_any(match_any), .is_write(wr_q), .resp_ready(resp_ready), .resp_hit(resp_hit),
  .mem_req_valid(mem_req_valid)
);

// File: tb/tb_sa_cache.sv
`timescale 1ns/1ps
module tb_sa_cache;
  localparam int NW = 2, NS = 4, NWD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        rv [2];
  logic        rw [2];
  logic [15:0] ra [2];
  logic [31:0] rd [2];
  logic        resp_r [2];
  logic        resp_h [2];
  logic [31:0] resp_d [2];
  logic        mreq_v [2];
  logic [13:0] mreq_a [2];
  logic        mresp_v [2];
  logic [31:0] mresp_d [2];

  int checks = 0;
  int errors = 0;
  int nlog [2];
  logic [13:0] reqlog [2][16];

  logic        mv   [2][NS][NW];
  logic [8:0]  mt   [2][NS][NW];
  logic [31:0] mdat [2][NS][NW][NWD];
  int          mrr  [2][NS];

  function automatic logic [31:0] memf(input logic [13:0] a);
    return 32'(a) * 32'h9E37_79B1 + 32'h1234_5678;
  endfunction

  sa_cache #(.TWO_PHASE(0)) dut (
    .clk(clk), .rst(rst), .req_valid(rv[0]), .req_write(rw[0]), .req_addr(ra[0]), .req_wdata(rd[0]),
    .resp_ready(resp_r[0]), .resp_hit(resp_h[0]), .resp_rdata(resp_d[0]),
    .mem_req_valid(mreq_v[0]), .mem_req_addr(mreq_a[0]),
    .mem_resp_valid(mresp_v[0]), .mem_resp_data(mresp_d[0]));

  sa_cache #(.TWO_PHASE(1)) dut_tp (
    .clk(clk), .rst(rst), .req_valid(rv[1]), .req_write(rw[1]), .req_addr(ra[1]), .req_wdata(rd[1]),
    .resp_ready(resp_r[1]), .resp_hit(resp_h[1]), .resp_rdata(resp_d[1]),
    .mem_req_valid(mreq_v[1]), .mem_req_addr(mreq_a[1]),
    .mem_resp_valid(mresp_v[1]), .mem_resp_data(mresp_d[1]));

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      mresp_v[i] <= mreq_v[i];
      mresp_d[i] <= memf(mreq_a[i]);
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (mreq_v[i] === 1'b1) begin
        if (nlog[i] < 16) reqlog[i][nlog[i]] = mreq_a[i];
        nlog[i] = nlog[i] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input int w, input bit wr, input logic [8:0] tg, input int s,
                        input int k, input int b, input logic [31:0] wd, input string lbl);
    logic [15:0] a;
    bit ehit;
    int ev, lat, explat;
    logic [31:0] edata;
    a = {tg, 2'(s), 3'(k), 2'(b)};
    ehit = 0; ev = 0;
    for (int v = 0; v < NW; v++)
      if (mv[w][s][v] && mt[w][s][v] == tg) begin ehit = 1; ev = v; end
    if (!ehit) begin
      ev = mrr[w][s];
      mv[w][s][ev] = 1'b1;
      mt[w][s][ev] = tg;
      for (int j = 0; j < NWD; j++) mdat[w][s][ev][j] = memf({tg, 2'(s), 3'(j)});
      mrr[w][s] = (ev + 1) % NW;
    end
    if (wr) mdat[w][s][ev][k] = wd;
    edata = mdat[w][s][ev][k];

    @(negedge clk);
    nlog[w] = 0;
    rv[w] = 1'b1; rw[w] = wr; ra[w] = a; rd[w] = wd;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
    end while (resp_r[w] !== 1'b1 && lat < 100);

    explat = ehit ? ((wr || w == 1) ? 3 : 2) : 2 + 2 * NWD;
    chk(resp_r[w] === 1'b1, lbl, "response seen", 32'(resp_r[w]), 32'd1);
    chk(resp_h[w] === ehit, lbl, "hit flag", 32'(resp_h[w]), 32'(ehit));
    chk(lat == explat, lbl, "latency in edges", 32'(lat), 32'(explat));
    if (!wr) chk(resp_d[w] === edata, lbl, "load data", resp_d[w], edata);
    chk(nlog[w] == (ehit ? 0 : NWD), "R6", "refill request count", 32'(nlog[w]), 32'(ehit ? 0 : NWD));
    if (!ehit)
      for (int j = 0; j < NWD; j++)
        chk(reqlog[w][j] === {tg, 2'(s), 3'(j)}, "R6", "refill word address",
            32'(reqlog[w][j]), 32'({tg, 2'(s), 3'(j)}));

    @(negedge clk);
    rv[w] = 1'b0;
    @(posedge clk); #1;
    chk(resp_r[w] === 1'b0, "R11", "ready pulse ended", 32'(resp_r[w]), 32'd0);
  endtask

  task automatic run_sweep(input int w);
    string lbl;
    for (int s = 0; s < NS; s++) begin
      for (int t = 1; t <= 2; t++) begin
        lbl = (s == 0 && t == 1) ? "R1" : "R7";
        access(w, 1'b0, 9'(t * 7 + s), s, (t + s) % NWD, 0, 32'd0, lbl);
      end
    end
    for (int s = 0; s < NS; s++)
      for (int t = 1; t <= 2; t++)
        for (int k = 0; k < NWD; k++) begin
          if (k % 4 != 0)  lbl = "R2";
          else if (t == 2) lbl = "R10";
          else             lbl = (w == 0) ? "R3" : "R4";
          access(w, 1'b0, 9'(t * 7 + s), s, k, k % 4, 32'd0, lbl);
        end
    access(w, 1'b1, 9'(8),  1, 2, 0, 32'hCAFE_0000 + 32'(w), "R5");
    access(w, 1'b0, 9'(8),  1, 2, 1, 32'd0, "R5");
    access(w, 1'b1, 9'(15), 1, 5, 2, 32'hBEEF_0001 + 32'(w), "R5");
    access(w, 1'b0, 9'(15), 1, 5, 0, 32'd0, "R5");
    access(w, 1'b0, 9'(8),  1, 2, 0, 32'd0, "R10");
    access(w, 1'b1, 9'(30), 2, 4, 0, 32'h0DD0_5EED + 32'(w), "R8");
    access(w, 1'b0, 9'(30), 2, 4, 3, 32'd0, "R8");
    access(w, 1'b0, 9'(9),  2, 0, 0, 32'd0, "R9");
    access(w, 1'b0, 9'(30), 2, 1, 0, 32'd0, "R9");
    access(w, 1'b0, 9'(16), 2, 6, 0, 32'd0, "R9");
    access(w, 1'b0, 9'(30), 2, 4, 0, 32'd0, "R9");
    access(w, 1'b0, 9'(10), 3, 7, 0, 32'd0, "R9");
    access(w, 1'b0, 9'(17), 3, 3, 0, 32'd0, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      rv[i] = 1'b0; rw[i] = 1'b0; ra[i] = '0; rd[i] = '0; nlog[i] = 0;
      for (int s = 0; s < NS; s++) begin
        mrr[i][s] = 0;
        for (int v = 0; v < NW; v++) begin mv[i][s][v] = 1'b0; mt[i][s][v] = '0; end
      end
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 2; i++) begin
      chk(resp_r[i] === 1'b0, "R1", "ready after reset", 32'(resp_r[i]), 32'd0);
      chk(mreq_v[i] === 1'b0, "R1", "mem request after reset", 32'(mreq_v[i]), 32'd0);
    end
    run_sweep(0);
    run_sweep(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule